// File: doc/BRIEF.md
# Sliding-Window Descriptor Best-Match Search

This block keeps a short list of feature descriptors taken from the previous video frame. For each descriptor of the current frame that it is given, it returns the stored entry that lies closest to it. Closeness is the sum of absolute differences (SAD) taken over all descriptor elements. The block reports that smallest SAD together with the pixel coordinates that were stored with the winning entry.

The list is filled from an external descriptor queue. When a frame begins, up to sixteen entries are pulled in, one per cycle. After that, each slide strobe shifts the list forward by one place: the oldest entry is dropped and the next entry from the queue is appended. When the queue marks an entry as its last, the list stops moving. Every later search compares against the final group that was loaded. The block tells the queue when to advance by raising a take strobe.

All sixteen SAD values are formed in parallel, and a binary tree of compare-and-select stages reduces them to a single result. The result is registered, so it appears one cycle after the search request.

Top module: `sad_window_match`

## Requirements
- R1: An entry and a current descriptor hold 128 elements of 6 bits each. Element j sits in bits [6j+5:6j]. Coordinates form a 22-bit field, x in bits [10:0] and y in bits [21:11], and `res_xy` returns that field unchanged.
- R2: After reset and after `frame_start`, the window is empty. A search on an empty window returns `res_sad` = 4095 and `res_xy` = 0.
- R3: After `frame_start`, each cycle with `ld_valid` high raises `ld_take` and appends one entry, with no slide needed, until 16 entries have been taken.
- R4: Once 16 entries have been taken, an entry is taken only in a cycle where both `slide` and `ld_valid` are high. Each take drops the oldest entry.
- R5: Per entry, the SAD is the sum of element-wise absolute differences, capped at 4095. The result is the minimum over the loaded entries, with the coordinates of that entry.
- R6: When two or more entries share the minimum SAD, the one loaded earliest wins.
- R7: Entries that have not been loaded never win against a loaded entry, even a loaded entry whose SAD is 4095.
- R8: `res_valid` is high exactly in the cycle after a cycle in which `cur_valid` was high. `res_sad` and `res_xy` keep their values while no search is made.
- R9: Taking an entry that has `ld_last` high freezes the window. From then on `ld_take` stays low and the contents stay the same until the next `frame_start`.
- R10: A search made in the same cycle as a take compares against the window as it was before that take.
- R11: In a cycle with `frame_start` high, `ld_take` is low and no entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Empties the window and restarts the fill |
| ld_valid | input | 1 | Queue has an entry on `ld_desc`/`ld_xy` |
| ld_desc | input | 768 | Entry descriptor |
| ld_xy | input | 22 | Entry coordinates {y, x} |
| ld_last | input | 1 | Entry is the queue's final one |
| ld_take | output | 1 | Entry is accepted this cycle; queue advances |
| slide | input | 1 | A new current-frame feature arrived; advance the window |
| cur_valid | input | 1 | Search request |
| cur_desc | input | 768 | Current-frame descriptor |
| res_valid | output | 1 | Result valid |
| res_sad | output | 12 | Minimum SAD |
| res_xy | output | 22 | Coordinates of the winning entry |

## Verification
The search and the window shift can happen in the same cycle, because a new feature both requests a search and slides the window. The bench drives `cur_valid`, `slide` and `ld_valid` together in its random phase, with current descriptors formed as small perturbations of entries that are about to drop out. It judges each result against a model window that is updated only after the expected result has been computed, so a design that searches the post-shift window returns a different entry and a different SAD.

// File: rtl/sad_window_match.sv
module sad_window_match #(
  parameter int ELEMS = 128,
  parameter int EW    = 6,
  parameter int CW    = 11,
  parameter int DEPTH = 16,
  parameter int SW    = 12,
  localparam int DW   = ELEMS * EW,
  localparam int XYW  = 2 * CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           ld_valid,
  input  logic [DW-1:0]  ld_desc,
  input  logic [XYW-1:0] ld_xy,
  input  logic           ld_last,
  output logic           ld_take,
  input  logic           slide,
  input  logic           cur_valid,
  input  logic [DW-1:0]  cur_desc,
  output logic           res_valid,
  output logic [SW-1:0]  res_sad,
  output logic [XYW-1:0] res_xy
);
  localparam int RAW  = $clog2(ELEMS * ((1 << EW) - 1) + 1);
  localparam int FCW  = $clog2(DEPTH + 1);
  localparam logic [SW-1:0] SMAX = '1;

  logic [DW-1:0]  w_desc [DEPTH];
  logic [XYW-1:0] w_xy   [DEPTH];
  logic [DEPTH-1:0] w_vld;
  logic           frozen;
  logic [FCW-1:0] fill_cnt;

  assign ld_take = ld_valid && !frame_start && !frozen &&
                   ((fill_cnt < FCW'(DEPTH)) || slide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_vld    <= '0;
      frozen   <= 1'b0;
      fill_cnt <= '0;
    end else if (frame_start) begin
      w_vld    <= '0;
      frozen   <= 1'b0;
      fill_cnt <= '0;
    end else if (ld_take) begin
      w_vld  <= {1'b1, w_vld[DEPTH-1:1]};
      frozen <= ld_last;
      if (fill_cnt < FCW'(DEPTH)) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_take) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        w_desc[i] <= w_desc[i+1];
        w_xy[i]   <= w_xy[i+1];
      end
      w_desc[DEPTH-1] <= ld_desc;
      w_xy[DEPTH-1]   <= ld_xy;
    end
  end

  // heap-ordered tree: node n picks between 2n and 2n+1, leaves at DEPTH+e
  logic [SW:0]    nk [1:2*DEPTH-1];
  logic [XYW-1:0] nx [1:2*DEPTH-1];

  for (genvar e = 0; e < DEPTH; e++) begin : g_leaf
    logic [RAW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < ELEMS; j++) begin
        logic [EW-1:0] a, b;
        a = cur_desc[j*EW +: EW];
        b = w_desc[e][j*EW +: EW];
        acc = acc + RAW'((a > b) ? (a - b) : (b - a));
      end
    end
    assign nk[DEPTH+e] = w_vld[e] ? {1'b0, (acc > RAW'(SMAX)) ? SMAX : acc[SW-1:0]}
                                  : {1'b1, SMAX};
    assign nx[DEPTH+e] = w_vld[e] ? w_xy[e] : '0;
  end

  for (genvar n = 1; n < DEPTH; n++) begin : g_node
    logic take_r;
    assign take_r = nk[2*n+1] < nk[2*n];
    assign nk[n]  = take_r ? nk[2*n+1] : nk[2*n];
    assign nx[n]  = take_r ? nx[2*n+1] : nx[2*n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_sad   <= '0;
      res_xy    <= '0;
    end else begin
      res_valid <= cur_valid;
      if (cur_valid) begin
        res_sad <= nk[1][SW-1:0];
        res_xy  <= nx[1];
      end
    end
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    cur_valid |=> res_valid);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_valid |=> !res_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_valid |=> ($stable(res_sad) && $stable(res_xy)));
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (w_vld == '0));
  a_r4_newest: assert property (@(posedge clk) disable iff (!rst_n)
    ld_take |=> w_vld[DEPTH-1]);
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !ld_take);
  a_r11_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !ld_take);
endmodule

// File: tb/sad_window_match_test.sv
`timescale 1ns/1ps
module sad_window_match_test;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, ld_valid = 0, ld_last = 0, ld_take, slide = 0, cur_valid = 0;
  logic [767:0] ld_desc = '0, cur_desc = '0;
  logic [21:0] ld_xy = '0, res_xy;
  logic res_valid;
  logic [11:0] res_sad;

  always #2 clk = ~clk;

  sad_window_match uut (.clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .ld_valid(ld_valid), .ld_desc(ld_desc), .ld_xy(ld_xy), .ld_last(ld_last),
    .ld_take(ld_take), .slide(slide), .cur_valid(cur_valid), .cur_desc(cur_desc),
    .res_valid(res_valid), .res_sad(res_sad), .res_xy(res_xy));

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [767:0] m_desc [N];
  logic [21:0]  m_xy   [N];
  bit   m_vld [N];
  bit   m_frozen;
  int   m_cnt;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sad_of(input logic [767:0] a, input logic [767:0] b);
    int s = 0;
    for (int j = 0; j < 128; j++) begin
      int x = a[j*6 +: 6];
      int y = b[j*6 +: 6];
      s += (x > y) ? x - y : y - x;
    end
    return (s > 4095) ? 4095 : s;
  endfunction

  function automatic logic [767:0] rand_desc();
    logic [767:0] d;
    for (int j = 0; j < 128; j++) d[j*6 +: 6] = 6'($urandom_range(0, 63));
    return d;
  endfunction

  function automatic logic [767:0] perturb(input logic [767:0] d);
    logic [767:0] r = d;
    for (int k = 0; k < 6; k++) begin
      int j = $urandom_range(0, 127);
      r[j*6 +: 6] = 6'($urandom_range(0, 63));
    end
    return r;
  endfunction

  task automatic cyc(input bit fs, input bit lv, input logic [767:0] ld, input logic [21:0] lx,
                     input bit ll, input bit sl, input bit cv, input logic [767:0] cd, input string req);
    bit et;
    int es, ex;
    frame_start = fs; ld_valid = lv; ld_desc = ld; ld_xy = lx; ld_last = ll;
    slide = sl; cur_valid = cv; cur_desc = cd;
    #1;
    et = lv && !fs && !m_frozen && (m_cnt < N || sl);
    chk(ld_take == et, req, "ld_take", int'(ld_take), int'(et));
    es = 4095; ex = 0;
    begin
      bit found = 0;
      for (int i = 0; i < N; i++)
        if (m_vld[i]) begin
          int s = sad_of(cd, m_desc[i]);
          if (!found || s < es) begin es = s; ex = int'(m_xy[i]); found = 1; end
        end
    end
    @(posedge clk);
    if (fs) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
      m_frozen = 0; m_cnt = 0;
    end else if (et) begin
      for (int i = 0; i < N - 1; i++) begin
        m_desc[i] = m_desc[i+1]; m_xy[i] = m_xy[i+1]; m_vld[i] = m_vld[i+1];
      end
      m_desc[N-1] = ld; m_xy[N-1] = lx; m_vld[N-1] = 1;
      m_frozen = ll;
      if (m_cnt < N) m_cnt++;
    end
    @(negedge clk);
    chk(res_valid == cv, "R8", "res_valid", int'(res_valid), int'(cv));
    if (cv) begin
      chk(res_sad == 12'(es), req, "res_sad", int'(res_sad), es);
      chk(res_xy == 22'(ex), req, "res_xy", int'(res_xy), ex);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [767:0] z, d;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_frozen = 0; m_cnt = 0;
    z = '0;
    repeat (3) @(negedge clk);
    chk(res_valid == 0, "R2", "reset res_valid", int'(res_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 / R7: empty window search
    cyc(0, 0, z, 0, 0, 0, 1, rand_desc(), "R2");
    cyc(1, 0, z, 0, 0, 0, 0, z, "R2");
    cyc(0, 0, z, 0, 0, 0, 1, rand_desc(), "R7");
    // R3: fill, with partial-window searches (R7)
    for (int i = 0; i < N; i++) begin
      d = rand_desc();
      cyc(0, 1, d, 22'($urandom), 0, 0, (i % 3) == 1, perturb(d), "R3");
    end
    // R4: full window, ld_valid without slide must not be taken
    cyc(0, 1, rand_desc(), 22'h1, 0, 0, 0, z, "R4");
    // R4 / R5 / R10 / R1: random slide-and-search mix
    for (int t = 0; t < 300; t++) begin
      bit sl = $urandom_range(0, 1) == 1;
      bit cv = $urandom_range(0, 3) != 0;
      int k = (t % 4 == 0) ? 0 : $urandom_range(0, N - 1);
      d = perturb(m_desc[k]);
      cyc(0, $urandom_range(0, 7) != 0, rand_desc(), 22'($urandom), 0, sl, cv, d,
          (t % 2 == 0) ? "R10" : "R5");
    end
    // R5 saturation and R7 valid beats invalid at 4095
    cyc(1, 0, z, 0, 0, 0, 0, z, "R2");
    cyc(0, 1, z, 22'h2A5A5, 0, 0, 0, z, "R3");
    cyc(0, 0, z, 0, 0, 0, 1, '1, "R5");
    cyc(0, 0, z, 0, 0, 0, 1, '1, "R7");
    // R6: equal entries, older wins
    d = rand_desc();
    cyc(0, 1, d, 22'h00111, 0, 0, 0, z, "R3");
    cyc(0, 1, d, 22'h00222, 0, 0, 0, z, "R3");
    cyc(0, 0, z, 0, 0, 0, 1, d, "R6");
    chk(res_xy == 22'h00111, "R6", "tie winner", int'(res_xy), 'h111);
    // R9: last entry freezes window
    for (int i = 0; i < 12; i++) cyc(0, 1, rand_desc(), 22'($urandom), 0, 0, 0, z, "R3");
    cyc(0, 1, rand_desc(), 22'h3ABCD, 1, 1, 0, z, "R9");
    for (int i = 0; i < 6; i++) cyc(0, 1, rand_desc(), 22'($urandom), 0, 1, 1, perturb(m_desc[N-1]), "R9");
    // R11: frame_start beats a load
    cyc(1, 1, rand_desc(), 22'h5, 0, 1, 0, z, "R11");
    cyc(0, 0, z, 0, 0, 0, 1, rand_desc(), "R11");
    // R8: hold while idle
    d = rand_desc();
    cyc(0, 1, d, 22'h1234, 0, 0, 1, d, "R8");
    cyc(0, 0, z, 0, 0, 0, 1, d, "R8");
    cyc(0, 0, z, 0, 0, 0, 0, z, "R8");
    chk(res_xy == 22'h1234, "R8", "held xy", int'(res_xy), 'h1234);
    chk(res_sad == 12'd0, "R8", "held sad", int'(res_sad), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule